// File: doc/BRIEF.md
# Clear-on-Read Latched Status Bank

This block keeps a bank of sticky status bits fed by level error inputs from the core. Each bit has one of two polarities, fixed when the block is built. An active-low bit rests at 1 and drops to 0 when its error input is seen. An active-high bit rests at 0 and rises to 1. After a bit captures, it holds that value until software reads the 32-bit word that contains it. That read returns the held value and puts every bit of the word back to its resting level. An error input that is still high at that point captures the bit again on the next edge. A second read therefore tells a past event apart from a fault that is still present.

The bit count can be any value. The bits are packed into 32-bit words, and a small word address picks the word. Bits above the last used position read as zero. Error inputs are sampled on the core clock. A read is a single-cycle access with the write flag low. Its data comes back one cycle later with a valid strobe. A write access changes nothing.

Top module: `latched_status_bank`

## Requirements
- R1: The synchronous active-high reset `rst` puts every bit at its resting level. Resting level is 1 where `LOW_MASK` has a 1 and 0 elsewhere. `rdValid` is low after reset. With the defaults, word 0 reads 0x0000FFFF and word 1 reads 0x0000000F.
- R2: An active-high bit whose error input is high at a clock edge reads 1 from then on, until it is cleared.
- R3: An active-low bit whose error input is high at a clock edge reads 0 from then on, until it is cleared.
- R4: A read is `busValid`=1 with `busWrite`=0. In the next cycle it raises `rdValid` for exactly one cycle. `rdData` then holds the word as it stood before the read's own clear. Bit n of word k is status bit 32k+n.
- R5: After a read, each bit of that word with no active error is back at its resting level when the word is read again.
- R6: A bit whose error input stays high through a read shows the error state again on the next read.
- R7: An error that arrives in the same cycle as a read of its word is not lost. That read returns the older value, and the next read shows the error.
- R8: A write access (`busValid`=1, `busWrite`=1) changes no bit, clears nothing and does not raise `rdValid`.
- R9: A read clears only the bits of the addressed word. Captured bits in other words are kept.
- R10: A read at a word address of `NUM_WORDS` or above returns 0 with `rdValid` high and clears no bit.
- R11: A captured bit holds its error state through any number of cycles without a read, after its error input has gone low.
- R12: Bit positions in the last word above `NUM_BITS` always read 0. With the defaults, word 1 bits 31:8 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Access strobe for one cycle |
| busWrite | input | 1 | 1 marks the access as a write (ignored) |
| busAddr | input | ADDR_W | Word address of the access |
| errIn | input | NUM_BITS | Live error conditions, one per status bit |
| rdValid | output | 1 | Read data is valid this cycle |
| rdData | output | 32 | Word returned by the last read |

## Verification
The hardest case to reach is an error input that rises in exactly the cycle a read clears its word. Another is an error that stays high across several reads. Both need the error input and the bus strobe aligned to the same clock edge. The stimulus table therefore drives the error pattern and the access in the same vector. It runs sequences where an error starts together with a read, and where it persists over two further reads before dropping. Then two more reads show it staying latched once and then returning to rest.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

  localparam int WORD_W   = 32;
  localparam int IDX_MAXW = 8;

  typedef struct packed {
    logic                rdAny;
    logic                rdHit;
    logic [IDX_MAXW-1:0] wordIdx;
  } lsbCtrlT;

endpackage

// File: rtl/lsb_ctrl.sv
module lsb_ctrl
  import lsb_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 2
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output lsbCtrlT           ctrl
);

  logic isRead;
  logic inRange;

  always_comb begin
    isRead       = busValid && !busWrite;
    inRange      = 32'(busAddr) < NUM_WORDS;
    ctrl.rdAny   = isRead;
    ctrl.rdHit   = isRead && inRange;
    ctrl.wordIdx = IDX_MAXW'(busAddr);
  end

endmodule

// File: rtl/lsb_datapath.sv
module lsb_datapath
  import lsb_pkg::*;
#(
  parameter int                NUM_BITS = 40,
  parameter logic [NUM_BITS-1:0] LOW_MASK = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  lsbCtrlT             ctrl,
  input  logic [NUM_BITS-1:0] errIn,
  output logic                rdValid,
  output logic [WORD_W-1:0]   rdData
);

  localparam int NUM_WORDS = (NUM_BITS + WORD_W - 1) / WORD_W;
  localparam int PAD_BITS  = NUM_WORDS * WORD_W;
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [PAD_BITS-1:0] LOW_PAD = PAD_BITS'(LOW_MASK);

  // errFlag = 1 means an event was captured, whatever the polarity
  logic [PAD_BITS-1:0] errFlag;
  logic [PAD_BITS-1:0] viewVec;
  logic [WORD_W-1:0]   viewWord [NUM_WORDS];

  for (genvar i = 0; i < PAD_BITS; i++) begin : g_bit
    if (i < NUM_BITS) begin : g_used
      logic clrHere;
      assign clrHere = ctrl.rdHit && (ctrl.wordIdx == IDX_MAXW'(i / WORD_W));
      always_ff @(posedge clk) begin
        if (rst) begin
          errFlag[i] <= 1'b0;
        end else begin
          // a new event beats the clear
          errFlag[i] <= (errFlag[i] && !clrHere) || errIn[i];
        end
      end
    end else begin : g_pad
      assign errFlag[i] = 1'b0;
    end
  end

  assign viewVec = errFlag ^ LOW_PAD;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign viewWord[w] = viewVec[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= ctrl.rdAny;
      if (ctrl.rdAny) begin
        rdData <= ctrl.rdHit ? viewWord[ctrl.wordIdx[IDX_W-1:0]] : '0;
      end
    end
  end

endmodule

// File: rtl/latched_status_bank.sv
module latched_status_bank
  import lsb_pkg::*;
#(
  parameter int                  NUM_BITS = 40,
  parameter int                  ADDR_W   = 2,
  parameter logic [NUM_BITS-1:0] LOW_MASK = 40'h0F_0000_FFFF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_BITS-1:0] errIn,
  output logic                rdValid,
  output logic [31:0]         rdData
);

  localparam int NUM_WORDS = (NUM_BITS + WORD_W - 1) / WORD_W;

  lsbCtrlT ctrl;

  lsb_ctrl #(
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .ctrl    (ctrl)
  );

  lsb_datapath #(
    .NUM_BITS(NUM_BITS),
    .LOW_MASK(LOW_MASK)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .errIn  (errIn),
    .rdValid(rdValid),
    .rdData (rdData)
  );

endmodule

// File: rtl/lsb_checker.sv
module lsb_checker #(
  parameter int                  NUM_BITS = 40,
  parameter int                  ADDR_W   = 2,
  parameter logic [NUM_BITS-1:0] LOW_MASK = '0
) (
  input logic                clk,
  input logic                rst,
  input logic                busValid,
  input logic                busWrite,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [NUM_BITS-1:0] errIn,
  input logic                rdValid,
  input logic [31:0]         rdData
);

  localparam int NUM_WORDS = (NUM_BITS + 31) / 32;
  localparam int TOP_USED  = NUM_BITS - 32 * (NUM_WORDS - 1);
  localparam logic [31:0] PAD_MASK = ~(32'((64'(1) << TOP_USED) - 64'(1)));

  logic isRead, rdWord0, rdLast, rdOut;
  assign isRead  = busValid && !busWrite;
  assign rdWord0 = isRead && (32'(busAddr) == 0);
  assign rdLast  = isRead && (32'(busAddr) == NUM_WORDS - 1);
  assign rdOut   = isRead && (32'(busAddr) >= NUM_WORDS);

  // R4: a read is answered in the next cycle
  a_r4_read_valid: assert property (@(posedge clk) disable iff (rst)
    isRead |=> rdValid);

  // R8: no read data strobe unless a read was accepted
  a_r8_no_valid_on_write: assert property (@(posedge clk) disable iff (rst)
    !isRead |=> !rdValid);

  // R10: out-of-range reads return zero
  a_r10_out_of_range_zero: assert property (@(posedge clk) disable iff (rst)
    rdOut |=> (rdData == 32'h0));

  // R12: unused high positions of the last word stay zero
  a_r12_pad_zero: assert property (@(posedge clk) disable iff (rst)
    rdLast |=> ((rdData & PAD_MASK) == 32'h0));

  // R7: an error meeting the read of its word shows on the following read
  a_r7_same_cycle_error: assert property (@(posedge clk) disable iff (rst)
    (rdWord0 && errIn[0]) ##1 rdWord0 |=> (rdData[0] == !LOW_MASK[0]));

endmodule

bind latched_status_bank lsb_checker #(
  .NUM_BITS(NUM_BITS),
  .ADDR_W  (ADDR_W),
  .LOW_MASK(LOW_MASK)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busValid(busValid),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .errIn   (errIn),
  .rdValid (rdValid),
  .rdData  (rdData)
);

// File: tb/latched_status_bank_bench.sv
module latched_status_bank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [39:0] errIn = '0;
  logic        rdValid;
  logic [31:0] rdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  latched_status_bank u_latched_status_bank (
    .clk     (clk),
    .rst     (rst),
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .errIn   (errIn),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

  // op: 0 idle, 1 read, 2 write
  typedef struct packed {
    logic [39:0] err;
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [31:0] exp;
  } stepT;

  localparam int NSTEP = 18;
  localparam stepT STEPS [NSTEP] = '{
    '{40'h0,           2'd1, 2'd0, 32'h0000FFFF},
    '{40'h0,           2'd1, 2'd1, 32'h0000000F},
    '{40'h00_0001_0001, 2'd0, 2'd0, 32'h0},
    '{40'h0,           2'd1, 2'd0, 32'h0001FFFE},
    '{40'h0,           2'd1, 2'd0, 32'h0000FFFF},
    '{40'h42_0000_0000, 2'd0, 2'd0, 32'h0},
    '{40'h0,           2'd1, 2'd0, 32'h0000FFFF},
    '{40'h0,           2'd2, 2'd1, 32'h0},
    '{40'h0,           2'd1, 2'd1, 32'h0000004D},
    '{40'h0,           2'd1, 2'd1, 32'h0000000F},
    '{40'h00_0010_0000, 2'd1, 2'd0, 32'h0000FFFF},
    '{40'h00_0010_0000, 2'd1, 2'd0, 32'h0010FFFF},
    '{40'h00_0010_0000, 2'd1, 2'd0, 32'h0010FFFF},
    '{40'h0,           2'd1, 2'd0, 32'h0010FFFF},
    '{40'h0,           2'd1, 2'd0, 32'h0000FFFF},
    '{40'h00_0000_0020, 2'd1, 2'd3, 32'h00000000},
    '{40'h0,           2'd1, 2'd0, 32'h0000FFDF},
    '{40'h0,           2'd1, 2'd0, 32'h0000FFFF}
  };
  localparam string TAGS [NSTEP] = '{
    "R1", "R12", "R2", "R3", "R5", "R9", "R9", "R8", "R11",
    "R5", "R4", "R7", "R6", "R6", "R5", "R10", "R10", "R5"
  };

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [39:0] e, input logic [1:0] op, input logic [1:0] a);
    errIn    = e;
    busValid = (op != 2'd0);
    busWrite = (op == 2'd2);
    busAddr  = a;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: nothing valid straight after reset
    checkVal("R1", 32'(rdValid), 32'h0);

    for (int s = 0; s < NSTEP; s++) begin
      drive(STEPS[s].err, STEPS[s].op, STEPS[s].addr);
      @(negedge clk);
      checkVal(TAGS[s], 32'(rdValid), (STEPS[s].op == 2'd1) ? 32'h1 : 32'h0);
      if (STEPS[s].op == 2'd1) checkVal(TAGS[s], rdData, STEPS[s].exp);
    end

    // R12: every error of word 1 at once; positions above 39 stay zero
    drive(40'hFF_FFFF_FFFF, 2'd0, 2'd0);
    @(negedge clk);
    drive(40'h0, 2'd1, 2'd1);
    @(negedge clk);
    checkVal("R12", rdData, 32'h000000F0);
    drive(40'h0, 2'd1, 2'd0);
    @(negedge clk);
    checkVal("R2", rdData, 32'hFFFF0000);

    // R1: reset drops captured events
    drive(40'h01_0001_0001, 2'd0, 2'd0);
    @(negedge clk);
    drive(40'h0, 2'd0, 2'd0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    checkVal("R1", 32'(rdValid), 32'h0);
    drive(40'h0, 2'd1, 2'd0);
    @(negedge clk);
    checkVal("R1", rdData, 32'h0000FFFF);
    drive(40'h0, 2'd1, 2'd1);
    @(negedge clk);
    checkVal("R1", rdData, 32'h0000000F);
    drive(40'h0, 2'd0, 2'd0);
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule